// File: doc/BRIEF.md
# Debounced Up/Down Press Counter

This block turns two mechanical push-buttons into an 8-bit count shown on eight LEDs. One button steps the count up and the other steps it down. Everything runs on a single free-running system clock. The button lines are only ever sampled as data and never used as clocks or asynchronous controls.

Each raw button line passes through a multi-flop synchroniser and then a counter-based debounce filter. The filter's clean level changes only after the synchronised input has disagreed with it for `DEBOUNCE_CYCLES` consecutive clocks. The clean levels are registered once more, which keeps the previous level of each button. The previous and current levels of both buttons are decoded together. An up step happens only on a fresh rising edge of the up button while the down button is idle in both cycles. A down step follows the same rule with the buttons swapped. All other combinations leave the count unchanged.

The default filter window is 20 ms at 50 MHz. A test setup can shorten it through the parameter.

Top module: `press_counter`

## Requirements
- R1: While `rst` is high and after it falls with both buttons idle, `led` is 0 and stays 0.
- R2: An isolated press of the up button raises `led` by exactly one. Holding the button down does not add further steps.
- R3: An isolated press of the down button lowers `led` by exactly one. Holding the button down does not add further steps.
- R4: A pulse on either button line shorter than `DEBOUNCE_CYCLES` clocks has no effect on `led`.
- R5: A press or release that bounces, with every burst shorter than `DEBOUNCE_CYCLES` clocks, gives exactly one step per press. A release gives no step.
- R6: Pressing both buttons in the same cycle leaves `led` unchanged, and so does releasing both together.
- R7: Pressing one button while the other is already held leaves `led` unchanged.
- R8: The count wraps modulo 2^`COUNT_W`: 255 plus one gives 0, and 0 minus one gives 255.
- R9: After a clean edge on a button line, `led` changes exactly `SYNC_STAGES + DEBOUNCE_CYCLES + 1` rising clock edges later, counting from the first edge that samples the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_up_raw | input | 1 | Raw up button, high when pressed, asynchronous |
| btn_dn_raw | input | 1 | Raw down button, high when pressed, asynchronous |
| led | output | COUNT_W | Current count, one bit per LED |

## Verification
Some properties are checked on every cycle:
- the filter counter never passes its limit;
- a clean level changes only to a value that the synchronised input already showed in the previous cycle;
- a step pulse lasts a single cycle;
- the count never moves by more than one per clock;
- the count never moves while both clean levels were high.

Other behaviour is only visible in the bench scenarios:
- that bounce bursts and short glitches are fully absorbed;
- that overlapping presses produce nothing;
- the exact press-to-LED latency;
- the wrap in both directions, shown by sweeping the count around the full range up and back down.

// File: rtl/press_counter_pkg.sv
package press_counter_pkg;
   typedef enum logic [1:0] {
      STEP_NONE = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2
   } step_t;

   localparam int BTN_UP = 0;
   localparam int BTN_DN = 1;
   localparam int NUM_BTN = 2;
endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pc_debounce.sv
module pc_debounce #(
   parameter int HOLD = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level
);
   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("pc_debounce: HOLD must be at least 2");
      end
   endgenerate

   localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD);
   localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         level <= 1'b0;
         cnt   <= '0;
      end else if (din == level) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         level <= din;
         cnt   <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);

   // R4
   level_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(level) |-> (level == $past(din)) && ($past(din) != $past(level)));
endmodule

// File: rtl/pc_edge_step.sv
module pc_edge_step
   import press_counter_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  up_lvl,
   input  logic  dn_lvl,
   output step_t step
);
   logic up_prev, dn_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         up_prev <= 1'b0;
         dn_prev <= 1'b0;
      end else begin
         up_prev <= up_lvl;
         dn_prev <= dn_lvl;
      end
   end

   always_comb begin
      case ({dn_prev, dn_lvl, up_prev, up_lvl})
         4'b0001: step = STEP_INC;
         4'b0100: step = STEP_DEC;
         default: step = STEP_NONE;
      endcase
   end

   // R2
   inc_single_chk: assert property (@(posedge clk) disable iff (rst)
      step == STEP_INC |=> step != STEP_INC);

   // R3
   dec_single_chk: assert property (@(posedge clk) disable iff (rst)
      step == STEP_DEC |=> step != STEP_DEC);
endmodule

// File: rtl/press_counter.sv
module press_counter
   import press_counter_pkg::*;
#(
   parameter int COUNT_W         = 8,
   parameter int SYNC_STAGES     = 2,
   parameter int DEBOUNCE_CYCLES = 1_000_000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               btn_up_raw,
   input  logic               btn_dn_raw,
   output logic [COUNT_W-1:0] led
);
   generate
      if (COUNT_W < 1) begin : g_bad_width
         $error("press_counter: COUNT_W must be positive");
      end
   endgenerate

   logic [NUM_BTN-1:0] raw_vec;
   logic [NUM_BTN-1:0] sync_vec;
   logic [NUM_BTN-1:0] lvl_vec;
   step_t              step;

   assign raw_vec[BTN_UP] = btn_up_raw;
   assign raw_vec[BTN_DN] = btn_dn_raw;

   generate
      for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
         pc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw_vec[b]),
            .q   (sync_vec[b])
         );
         pc_debounce #(.HOLD(DEBOUNCE_CYCLES)) u_deb (
            .clk   (clk),
            .rst   (rst),
            .din   (sync_vec[b]),
            .level (lvl_vec[b])
         );
      end
   endgenerate

   pc_edge_step u_step (
      .clk    (clk),
      .rst    (rst),
      .up_lvl (lvl_vec[BTN_UP]),
      .dn_lvl (lvl_vec[BTN_DN]),
      .step   (step)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         led <= '0;
      end else begin
         case (step)
            STEP_INC: led <= led + 1'b1;
            STEP_DEC: led <= led - 1'b1;
            default:  led <= led;
         endcase
      end
   end

   // R2
   step_size_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(led) |-> (led == $past(led) + 1'b1) || (led == $past(led) - 1'b1));

   // R6
   both_held_chk: assert property (@(posedge clk) disable iff (rst)
      $past(lvl_vec[BTN_UP] && lvl_vec[BTN_DN]) |-> $stable(led));
endmodule

// File: tb/press_counter_test.sv
module press_counter_test;
   localparam int W     = 8;
   localparam int SYNC  = 2;
   localparam int N     = 8;
   localparam int LAT   = SYNC + N + 1;
   localparam int SETTLE = N + 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         up_raw = 1'b0;
   logic         dn_raw = 1'b0;
   logic [W-1:0] led;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [W-1:0] exp_cnt = '0;

   always #2 clk = ~clk;

   press_counter #(.COUNT_W(W), .SYNC_STAGES(SYNC), .DEBOUNCE_CYCLES(N)) uut (
      .clk        (clk),
      .rst        (rst),
      .btn_up_raw (up_raw),
      .btn_dn_raw (dn_raw),
      .led        (led)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_btn(input bit u, input bit d, input logic v);
      if (u) up_raw = v;
      if (d) dn_raw = v;
   endtask

   // bounce bursts all shorter than N, ending at level v and held
   task automatic bouncy(input bit u, input bit d, input logic v);
      int seg[6] = '{2, 1, 3, 2, 1, 1};
      for (int i = 0; i < 6; i++) begin
         set_btn(u, d, (i % 2 == 0) ? v : ~v);
         wait_neg(seg[i]);
      end
      set_btn(u, d, v);
      wait_neg(SETTLE);
   endtask

   initial begin
      wait_neg(4);
      check("R1 in reset", led, 8'd0);
      rst = 1'b0;
      wait_neg(3 * N);
      check("R1 idle after reset", led, 8'd0);

      // R9 exact latency on a clean up edge
      set_btn(1, 0, 1'b1);
      wait_neg(LAT - 1);
      check("R9 before latency", led, exp_cnt);
      wait_neg(1);
      exp_cnt = exp_cnt + 1'b1;
      check("R9 at latency", led, exp_cnt);
      wait_neg(4 * N);
      check("R2 hold no repeat", led, exp_cnt);
      set_btn(1, 0, 1'b0);
      wait_neg(SETTLE);
      check("R5 clean release no step", led, exp_cnt);

      // R4 glitches of every length below the window
      for (int len = 1; len < N; len++) begin
         set_btn(1, 0, 1'b1); wait_neg(len);
         set_btn(1, 0, 1'b0); wait_neg(N);
         set_btn(0, 1, 1'b1); wait_neg(len);
         set_btn(0, 1, 1'b0); wait_neg(SETTLE);
         check("R4 short pulse", led, exp_cnt);
      end

      // R6 simultaneous press and release
      set_btn(1, 1, 1'b1); wait_neg(SETTLE);
      check("R6 both pressed", led, exp_cnt);
      set_btn(1, 1, 1'b0); wait_neg(SETTLE);
      check("R6 both released", led, exp_cnt);

      // R7 overlap: up held, then down pressed and released
      bouncy(1, 0, 1'b1);
      exp_cnt = exp_cnt + 1'b1;
      check("R7 first press counts", led, exp_cnt);
      bouncy(0, 1, 1'b1);
      check("R7 down while up held", led, exp_cnt);
      bouncy(0, 1, 1'b0);
      bouncy(1, 0, 1'b0);
      check("R7 overlap released", led, exp_cnt);
      bouncy(0, 1, 1'b1);
      exp_cnt = exp_cnt - 1'b1;
      bouncy(1, 0, 1'b1);
      check("R7 up while down held", led, exp_cnt);
      bouncy(1, 0, 1'b0);
      bouncy(0, 1, 1'b0);
      check("R7 second overlap released", led, exp_cnt);

      // R2 R5 R8 full sweep up through the wrap
      for (int i = 0; i < 260; i++) begin
         bouncy(1, 0, 1'b1);
         exp_cnt = exp_cnt + 1'b1;
         check("R2 R8 bouncy up press", led, exp_cnt);
         bouncy(1, 0, 1'b0);
         check("R5 bouncy up release", led, exp_cnt);
      end

      // R3 R5 R8 full sweep down through the wrap
      for (int i = 0; i < 260; i++) begin
         bouncy(0, 1, 1'b1);
         exp_cnt = exp_cnt - 1'b1;
         check("R3 R8 bouncy down press", led, exp_cnt);
         bouncy(0, 1, 1'b0);
         check("R5 bouncy down release", led, exp_cnt);
      end

      // R8 explicit boundaries from reset
      rst = 1'b1; wait_neg(3); rst = 1'b0; wait_neg(3);
      exp_cnt = '0;
      check("R1 reset again", led, exp_cnt);
      bouncy(0, 1, 1'b1); bouncy(0, 1, 1'b0);
      exp_cnt = 8'hFF;
      check("R8 zero minus one", led, exp_cnt);
      bouncy(1, 0, 1'b1); bouncy(1, 0, 1'b0);
      exp_cnt = 8'h00;
      check("R8 max plus one", led, exp_cnt);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule